// File: doc/BRIEF.md
# Loop-Exit Condition and Countdown Unit

This unit decides, for a counted loop, whether control goes back to the loop head or drops out of the loop. Each cycle it looks at a 4-bit condition selector and the N, Z, V and C condition flags. If the selected condition holds, the loop ends early. The branch is not taken and the counter word passes through untouched. If the condition does not hold, the 16-bit counter word is decremented. The branch back is taken unless the decremented count has wrapped to all ones (-1), which marks the end of the count.

The unit also forms the branch target address. It adds the sign-extended 16-bit displacement to the 32-bit program counter. Every result is registered, so the outcome of one set of inputs appears after the next rising clock edge. Instruction decoding, fetching and the write-back of the counter into a register file belong to the surrounding pipeline. That pipeline uses the counter write-enable and the counter result.

Top module: `loop_branch_unit`

## Requirements
- R1: When the selected condition is true, after the next clock edge take_branch is 0, count_we is 0 and count_out equals the count_in that was sampled.
- R2: When the selected condition is false, after the next clock edge count_we is 1 and count_out equals count_in minus 1, modulo 2^16.
- R3: When the condition is false and the decremented count is 16'hFFFF (count_in was 0), take_branch is 0.
- R4: When the condition is false and the decremented count is not 16'hFFFF, take_branch is 1. take_branch is never 1 while count_we is 0.
- R5: target_addr equals pc_in plus disp_in sign-extended to 32 bits, modulo 2^32, one clock edge after the inputs are presented.
- R6: Selector 0 is always true, so the unit never branches and never writes the counter. Selector 1 is always false, so the unit works as a plain counted loop.
- R7: The unsigned and single-flag selectors are true as follows: 2 when !C && !Z, 3 when C or Z, 4 when !C, 5 when C, 6 when !Z, 7 when Z, 8 when !V, 9 when V.
- R8: The sign-based selectors are true as follows: 10 when !N, 11 when N, 12 when N==V, 13 when N!=V, 14 when !Z && N==V, 15 when Z or N!=V.
- R9: While rst is high at a clock edge, all outputs are cleared to 0 at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cond_sel | input | 4 | Condition selector, encodings as in R6 to R8 |
| flag_n | input | 1 | Negative flag |
| flag_z | input | 1 | Zero flag |
| flag_v | input | 1 | Overflow flag |
| flag_c | input | 1 | Carry flag |
| count_in | input | 16 | Low word of the loop counter register |
| pc_in | input | 32 | Program counter the displacement is added to |
| disp_in | input | 16 | Signed branch displacement |
| take_branch | output | 1 | Branch back to the loop head |
| target_addr | output | 32 | Branch target address |
| count_out | output | 16 | Counter word to write back |
| count_we | output | 1 | Counter write-enable |

## Verification
Every output sits one register stage behind the inputs. The branch decision, the counter result, its write-enable and the target address for a set of inputs are therefore all valid together, one rising edge after those inputs were applied. The bench changes inputs on the falling edge. It waits for the next rising edge and then samples one time unit later, so it always compares against the inputs of the previous half cycle. The checker properties use the same one-edge relation, through |=> and $past.

// File: rtl/loop_branch_pkg.sv
package loop_branch_pkg;

  typedef enum logic [3:0] {
    SEL_TRUE  = 4'd0,
    SEL_FALSE = 4'd1,
    SEL_HI    = 4'd2,
    SEL_LS    = 4'd3,
    SEL_CC    = 4'd4,
    SEL_CS    = 4'd5,
    SEL_NE    = 4'd6,
    SEL_EQ    = 4'd7,
    SEL_VC    = 4'd8,
    SEL_VS    = 4'd9,
    SEL_PL    = 4'd10,
    SEL_MI    = 4'd11,
    SEL_GE    = 4'd12,
    SEL_LT    = 4'd13,
    SEL_GT    = 4'd14,
    SEL_LE    = 4'd15
  } cond_sel_e;

  typedef struct packed {
    logic n;
    logic z;
    logic v;
    logic c;
  } ccr_flags_t;

endpackage

// File: rtl/lbu_cond_eval.sv
module lbu_cond_eval
  import loop_branch_pkg::*;
(
  input  cond_sel_e  sel,
  input  ccr_flags_t flags,
  output logic       holds
);
  logic sign_ok;

  assign sign_ok = (flags.n == flags.v);

  always_comb begin
    unique case (sel)
      SEL_TRUE:  holds = 1'b1;
      SEL_FALSE: holds = 1'b0;
      SEL_HI:    holds = ~flags.c & ~flags.z;
      SEL_LS:    holds = flags.c | flags.z;
      SEL_CC:    holds = ~flags.c;
      SEL_CS:    holds = flags.c;
      SEL_NE:    holds = ~flags.z;
      SEL_EQ:    holds = flags.z;
      SEL_VC:    holds = ~flags.v;
      SEL_VS:    holds = flags.v;
      SEL_PL:    holds = ~flags.n;
      SEL_MI:    holds = flags.n;
      SEL_GE:    holds = sign_ok;
      SEL_LT:    holds = ~sign_ok;
      SEL_GT:    holds = ~flags.z & sign_ok;
      SEL_LE:    holds = flags.z | ~sign_ok;
      default:   holds = 1'b0;
    endcase
  end
endmodule

// File: rtl/lbu_count_step.sv
module lbu_count_step #(
  parameter int CNT_W = 16
) (
  input  logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] cnt_dec,
  output logic             expired
);
  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  assign cnt_dec = cnt - ONE;
  // the decrement wraps to all ones exactly when the input was zero
  assign expired = (cnt == '0);
endmodule

// File: rtl/lbu_target_add.sv
module lbu_target_add #(
  parameter int ADDR_W = 32,
  parameter int DISP_W = 16
) (
  input  logic [ADDR_W-1:0] pc,
  input  logic [DISP_W-1:0] disp,
  output logic [ADDR_W-1:0] target
);
  localparam int EXT_W = ADDR_W - DISP_W;

  logic [ADDR_W-1:0] disp_ext;

  assign disp_ext = {{EXT_W{disp[DISP_W-1]}}, disp};
  assign target   = pc + disp_ext;
endmodule

// File: rtl/loop_branch_unit.sv
module loop_branch_unit
  import loop_branch_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 32,
  parameter int DISP_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [3:0]        cond_sel,
  input  logic              flag_n,
  input  logic              flag_z,
  input  logic              flag_v,
  input  logic              flag_c,
  input  logic [CNT_W-1:0]  count_in,
  input  logic [ADDR_W-1:0] pc_in,
  input  logic [DISP_W-1:0] disp_in,
  output logic              take_branch,
  output logic [ADDR_W-1:0] target_addr,
  output logic [CNT_W-1:0]  count_out,
  output logic              count_we
);
  ccr_flags_t        flags;
  logic              cond_holds;
  logic [CNT_W-1:0]  cnt_next;
  logic              cnt_expired;
  logic [ADDR_W-1:0] tgt_next;

  assign flags = '{n: flag_n, z: flag_z, v: flag_v, c: flag_c};

  lbu_cond_eval u_cond (
    .sel   (cond_sel_e'(cond_sel)),
    .flags (flags),
    .holds (cond_holds)
  );

  lbu_count_step #(.CNT_W(CNT_W)) u_step (
    .cnt     (count_in),
    .cnt_dec (cnt_next),
    .expired (cnt_expired)
  );

  lbu_target_add #(.ADDR_W(ADDR_W), .DISP_W(DISP_W)) u_tgt (
    .pc     (pc_in),
    .disp   (disp_in),
    .target (tgt_next)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      take_branch <= 1'b0;
      target_addr <= '0;
      count_out   <= '0;
      count_we    <= 1'b0;
    end else begin
      target_addr <= tgt_next;
      if (cond_holds) begin
        take_branch <= 1'b0;
        count_out   <= count_in;
        count_we    <= 1'b0;
      end else begin
        take_branch <= ~cnt_expired;
        count_out   <= cnt_next;
        count_we    <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/loop_branch_unit_chk.sv
module loop_branch_unit_chk #(
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 32,
  parameter int DISP_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic [3:0]        cond_sel,
  input logic [CNT_W-1:0]  count_in,
  input logic [ADDR_W-1:0] pc_in,
  input logic [DISP_W-1:0] disp_in,
  input logic              take_branch,
  input logic [ADDR_W-1:0] target_addr,
  input logic [CNT_W-1:0]  count_out,
  input logic              count_we
);
  localparam logic [CNT_W-1:0] ALL_ONES = '1;
  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  p_reset_clear_r9: assert property (@(posedge clk)
    rst |=> (!take_branch && !count_we && count_out == '0 && target_addr == '0));

  p_hold_when_no_write_r1: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (count_we || (count_out == $past(count_in) && !take_branch)));

  p_branch_needs_write_r4: assert property (@(posedge clk) disable iff (rst)
    take_branch |-> count_we);

  p_fall_through_at_end_r3: assert property (@(posedge clk) disable iff (rst)
    (count_we && count_out == ALL_ONES) |-> !take_branch);

  p_always_true_r6: assert property (@(posedge clk) disable iff (rst)
    (cond_sel == 4'd0) |=> (!take_branch && !count_we));

  p_always_false_r6: assert property (@(posedge clk) disable iff (rst)
    (cond_sel == 4'd1) |=> (count_we && count_out == $past(count_in) - ONE));

  p_target_sum_r5: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (target_addr == $past(pc_in)
              + {{(ADDR_W-DISP_W){$past(disp_in[DISP_W-1])}}, $past(disp_in)}));
endmodule

bind loop_branch_unit loop_branch_unit_chk #(
  .CNT_W(CNT_W), .ADDR_W(ADDR_W), .DISP_W(DISP_W)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .cond_sel    (cond_sel),
  .count_in    (count_in),
  .pc_in       (pc_in),
  .disp_in     (disp_in),
  .take_branch (take_branch),
  .target_addr (target_addr),
  .count_out   (count_out),
  .count_we    (count_we)
);

// File: tb/loop_branch_unit_tb.sv
module loop_branch_unit_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  cond_sel = '0;
  logic        flag_n = 0, flag_z = 0, flag_v = 0, flag_c = 0;
  logic [15:0] count_in = '0;
  logic [31:0] pc_in = '0;
  logic [15:0] disp_in = '0;
  logic        take_branch;
  logic [31:0] target_addr;
  logic [15:0] count_out;
  logic        count_we;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  loop_branch_unit u_dut (
    .clk(clk), .rst(rst), .cond_sel(cond_sel),
    .flag_n(flag_n), .flag_z(flag_z), .flag_v(flag_v), .flag_c(flag_c),
    .count_in(count_in), .pc_in(pc_in), .disp_in(disp_in),
    .take_branch(take_branch), .target_addr(target_addr),
    .count_out(count_out), .count_we(count_we)
  );

  // reference truth table from R6, R7, R8; flags packed as {n,z,v,c}
  function automatic bit ref_cond(input logic [3:0] s, input logic [3:0] f);
    bit n, z, v, c;
    {n, z, v, c} = f;
    case (s)
      4'd0:  return 1;
      4'd1:  return 0;
      4'd2:  return !(c || z);
      4'd3:  return c || z;
      4'd4:  return !c;
      4'd5:  return c;
      4'd6:  return !z;
      4'd7:  return z;
      4'd8:  return !v;
      4'd9:  return v;
      4'd10: return !n;
      4'd11: return n;
      4'd12: return n ~^ v;
      4'd13: return n ^ v;
      4'd14: return !z && (n ~^ v);
      default: return z || (n ^ v);
    endcase
  endfunction

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // apply one set of inputs, then check all outputs one edge later
  task automatic step(input string req, input logic [3:0] s, input logic [3:0] f,
                      input logic [15:0] cnt, input logic [31:0] pc,
                      input logic [15:0] d);
    bit hit;
    logic [15:0] e_cnt;
    bit e_take, e_we;
    @(negedge clk);
    cond_sel = s; {flag_n, flag_z, flag_v, flag_c} = f;
    count_in = cnt; pc_in = pc; disp_in = d;
    hit = ref_cond(s, f);
    if (hit) begin
      e_cnt = cnt; e_we = 0; e_take = 0;
    end else begin
      e_cnt = cnt - 16'd1; e_we = 1; e_take = (cnt != 16'd0);
    end
    @(posedge clk); #1;
    check(req, "take_branch", {31'd0, take_branch}, {31'd0, e_take});
    check(req, "count_we",    {31'd0, count_we},    {31'd0, e_we});
    check(req, "count_out",   {16'd0, count_out},   {16'd0, e_cnt});
    check("R5", "target_addr", target_addr, pc + {{16{d[15]}}, d});
  endtask

  task automatic t_reset();
    @(negedge clk);
    rst = 1; cond_sel = 4'd1; count_in = 16'd9; pc_in = 32'h100; disp_in = 16'h10;
    @(posedge clk); #1;
    check("R9", "take_branch", {31'd0, take_branch}, 32'd0);
    check("R9", "count_we",    {31'd0, count_we},    32'd0);
    check("R9", "count_out",   {16'd0, count_out},   32'd0);
    check("R9", "target_addr", target_addr, 32'd0);
    @(negedge clk); rst = 0;
  endtask

  task automatic t_always_true();
    step("R6", 4'd0, 4'b0000, 16'h0005, 32'h1000, 16'hFFF0);
    step("R1", 4'd0, 4'b1111, 16'h0000, 32'h2000, 16'h0004);
  endtask

  task automatic t_counted_loop();
    logic [15:0] c = 16'd3;
    for (int i = 0; i < 4; i++) begin
      step(i == 3 ? "R3" : "R4", 4'd1, 4'b0101, c, 32'h0000_0400, 16'hFFFA);
      c = c - 16'd1;
    end
    step("R2", 4'd1, 4'b0000, 16'hFFFF, 32'h8000_0000, 16'h7FFF);
    step("R2", 4'd1, 4'b0000, 16'h8000, 32'hFFFF_FFF0, 16'h0020);
  endtask

  task automatic t_unsigned_flags();
    for (int s = 2; s <= 9; s++)
      for (int f = 0; f < 16; f++)
        step("R7", 4'(s), 4'(f), 16'(f), 32'h0001_0000 + 32'(s), 16'(16'hFF00 + f));
  endtask

  task automatic t_signed_flags();
    for (int s = 10; s <= 15; s++)
      for (int f = 0; f < 16; f++)
        step("R8", 4'(s), 4'(f), 16'(s * 3 + f), 32'h0002_0000, 16'(f * 8));
  endtask

  task automatic t_target_edges();
    step("R5", 4'd0, 4'b0000, 16'd1, 32'h0000_0004, 16'h8000);
    step("R5", 4'd0, 4'b0000, 16'd1, 32'hFFFF_FFFE, 16'h0004);
  endtask

  initial begin
    repeat (2) @(posedge clk);
    t_reset();
    t_always_true();
    t_counted_loop();
    t_unsigned_flags();
    t_signed_flags();
    t_target_edges();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule